// File: doc/BRIEF.md
# Descriptor Queue Manager

This block keeps a set of hardware queues of packet descriptor pointers. A client appends a descriptor to a queue by presenting a pointer and a queue number on the push port. It takes the oldest descriptor off a queue by presenting a queue number on the pop port, and the pointer comes back a fixed number of cycles later. No queue has a FIFO of its own. Every queue is a singly linked list threaded through one shared link memory, and the memory is indexed by descriptor number.

A small region table turns descriptor addresses into link indices. Each region gives a base address, a power-of-two descriptor size, a descriptor count and the link index of its first descriptor. The low four bits of a pointer are a size hint that travels with the descriptor. For every queue the block keeps an entry count and a byte count. It also holds a programmable threshold that drives one status flag per queue. The block answers only to a window of absolute queue numbers that starts at a base parameter, so several copies can share one queue number space.

Top module: `qmQueueMgr`

## Requirements
- R1: After reset `busy`, `popDone` and `pushErr` are low. Every queue reads entry count 0 and byte count 0, and every bit of `thrFlag` is 0.
- R2: A push appends to the tail of its queue and a pop returns the head. Pops on one queue return pointers in push order. The returned value equals the pushed 32-bit pointer, size hint included.
- R3: Region k written through the config port covers the addresses base + j*2^n, where 0 <= j < count and n >= 4, and maps address j to link index link + j. The lowest-numbered matching region wins. Bits [3:0] of the pointer take no part in the mapping.
- R4: A push is rejected when bits [31:4] of its pointer are in no region, are not on a descriptor boundary, or map to an index of NUM_DESC or more. It is also rejected when its queue number is outside [QUEUE_BASE, QUEUE_BASE+NUM_QUEUES). A rejected push raises `pushErr` for exactly one cycle and changes no queue's counts.
- R5: A pop from an empty queue, or from a queue number outside the window, completes with `popData` = 0 and changes no queue's counts.
- R6: Each queue's byte count grows by (hint+1)*16 on a push and shrinks by the same amount when that descriptor is popped. The entry count goes up by one per push and down by one per pop.
- R7: A threshold write stores 8 bits for its queue. When bit 7 is 1, `thrFlag[q]` = (count >= bits[6:0]). When bit 7 is 0, `thrFlag[q]` = (count < bits[6:0]). Bit q is relative to QUEUE_BASE, and writes to queue numbers outside the window are ignored.
- R8: When push and pop requests are accepted in the same cycle, the push is carried out first. A pop of an empty queue that is pushed in that same cycle returns the pushed pointer.
- R9: A request is taken only on an edge where `busy` is low. Requests that arrive while busy is high are dropped. After acceptance, `busy` stays high for 1 cycle for a push, 2 for a pop and 3 for a push with a pop. `pushErr` appears in the cycle after a push's busy cycle. `popDone` is a one-cycle pulse after the last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push request |
| pushQueue | input | 8 | Absolute queue number for push |
| pushPtr | input | 32 | Descriptor pointer; [3:0] size hint |
| popValid | input | 1 | Pop request |
| popQueue | input | 8 | Absolute queue number for pop |
| cfgWr | input | 1 | Region table write |
| cfgSel | input | 1 | Region number |
| cfgBase | input | 32 | Region base address |
| cfgLog2 | input | 5 | log2 of descriptor size (>= 4) |
| cfgCount | input | 7 | Descriptors in region |
| cfgLink | input | 6 | Link index of first descriptor |
| thrWr | input | 1 | Threshold write |
| thrQueue | input | 8 | Absolute queue number for threshold |
| thrData | input | 8 | Bit 7 compare mode, [6:0] level |
| statQueue | input | 8 | Absolute queue number to report |
| statCount | output | 7 | Entry count of statQueue (0 if outside window) |
| statBytes | output | 15 | Byte count of statQueue (0 if outside window) |
| thrFlag | output | 8 | Threshold flag per queue |
| busy | output | 1 | Operation in progress |
| popData | output | 32 | Popped pointer, 0 when nothing was popped |
| popDone | output | 1 | Pop result valid pulse |
| pushErr | output | 1 | Rejected push pulse |

## Verification
The assertions watch the handshake on every cycle. They check that a pop result only follows two busy cycles and that error and done pulses last one cycle. They also check that a rejected push follows a busy cycle and never lands on the same cycle as a pop result. Whether the data is right is something only the scenarios can show. That covers link order across interleaved queues, the region arithmetic at the last descriptor of a region, byte accounting, threshold polarity, and push-before-pop on an empty queue. The bench checks these against its own per-queue model.

// File: rtl/qmPkg.sv
package qmPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POPRD,
    ST_POPFIN
  } qmState_t;

  typedef struct packed {
    logic latchPush;
    logic latchPop;
    logic doPush;
    logic popRd;
    logic popFin;
  } qmStrobe_t;

endpackage

// File: rtl/qmLinkRam.sv
module qmLinkRam #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/qmRegionMap.sv
module qmRegionMap #(
  parameter int ADDR_W   = 32,
  parameter int NUM_REG  = 2,
  parameter int NUM_DESC = 64,
  localparam int IDX_W = $clog2(NUM_DESC),
  localparam int CNT_W = $clog2(NUM_DESC + 1),
  localparam int REG_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic [ADDR_W-1:0] regBase  [NUM_REG],
  input  logic [4:0]        regLog2  [NUM_REG],
  input  logic [CNT_W-1:0]  regCount [NUM_REG],
  input  logic [IDX_W-1:0]  regLink  [NUM_REG],
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              lookHit,
  output logic [IDX_W-1:0]  lookIdx,
  output logic [REG_W-1:0]  lookReg,
  input  logic [REG_W-1:0]  revReg,
  input  logic [IDX_W-1:0]  revIdx,
  output logic [ADDR_W-1:0] revAddr
);
  logic              hitR [NUM_REG];
  logic [IDX_W-1:0]  idxR [NUM_REG];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    logic [ADDR_W-1:0] offset, slot, sum, lowMask;
    always_comb begin
      offset  = lookAddr - regBase[r];
      slot    = offset >> regLog2[r];
      lowMask = ~({ADDR_W{1'b1}} << regLog2[r]);
      sum     = ADDR_W'(regLink[r]) + slot;
      hitR[r] = (lookAddr >= regBase[r]) && ((offset & lowMask) == '0) &&
                (slot < ADDR_W'(regCount[r])) && (sum < ADDR_W'(NUM_DESC));
      idxR[r] = sum[IDX_W-1:0];
    end
  end

  always_comb begin
    lookHit = 1'b0;
    lookIdx = '0;
    lookReg = '0;
    for (int r = NUM_REG - 1; r >= 0; r--) begin
      if (hitR[r]) begin
        lookHit = 1'b1;
        lookIdx = idxR[r];
        lookReg = REG_W'(r);
      end
    end
  end

  logic [IDX_W-1:0] revSlot;
  always_comb begin
    revSlot = revIdx - regLink[revReg];
    revAddr = regBase[revReg] + (ADDR_W'(revSlot) << regLog2[revReg]);
  end
endmodule

// File: rtl/qmCtrl.sv
module qmCtrl
  import qmPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pushValid,
  input  logic      popValid,
  output qmStrobe_t stb,
  output logic      busy
);
  qmState_t state, nextState;
  logic     pendPop;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (pushValid) begin
          stb.latchPush = 1'b1;
          stb.latchPop  = popValid;
          nextState     = ST_PUSH;
        end else if (popValid) begin
          stb.latchPop = 1'b1;
          nextState    = ST_POPRD;
        end
      end
      ST_PUSH: begin
        stb.doPush = 1'b1;
        nextState  = pendPop ? ST_POPRD : ST_IDLE;
      end
      ST_POPRD: begin
        stb.popRd = 1'b1;
        nextState = ST_POPFIN;
      end
      default: begin
        stb.popFin = 1'b1;
        nextState  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pendPop <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE) pendPop <= pushValid && popValid;
      else if (state == ST_PUSH) pendPop <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/qmDatapath.sv
module qmDatapath
  import qmPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int QNUM_W     = 8,
  parameter int NUM_QUEUES = 8,
  parameter int QUEUE_BASE = 16,
  parameter int NUM_DESC   = 64,
  parameter int NUM_REG    = 2,
  localparam int IDX_W  = $clog2(NUM_DESC),
  localparam int CNT_W  = $clog2(NUM_DESC + 1),
  localparam int BYTE_W = CNT_W + 8,
  localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int QIDX_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  qmStrobe_t         stb,
  input  logic [QNUM_W-1:0] pushQueue,
  input  logic [ADDR_W-1:0] pushPtr,
  input  logic [QNUM_W-1:0] popQueue,
  input  logic              cfgWr,
  input  logic [REG_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [4:0]        cfgLog2,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [IDX_W-1:0]  cfgLink,
  input  logic              thrWr,
  input  logic [QNUM_W-1:0] thrQueue,
  input  logic [7:0]        thrData,
  input  logic [QNUM_W-1:0] statQueue,
  output logic [CNT_W-1:0]  statCount,
  output logic [BYTE_W-1:0] statBytes,
  output logic [NUM_QUEUES-1:0] thrFlag,
  output logic [ADDR_W-1:0] popData,
  output logic              popDone,
  output logic              pushErr
);
  function automatic logic inWin(input logic [QNUM_W-1:0] q);
    return (int'(q) >= QUEUE_BASE) && (int'(q) < QUEUE_BASE + NUM_QUEUES);
  endfunction

  function automatic logic [QIDX_W-1:0] relQ(input logic [QNUM_W-1:0] q);
    return QIDX_W'(int'(q) - QUEUE_BASE);
  endfunction

  function automatic logic [BYTE_W-1:0] hintBytes(input logic [3:0] h);
    return BYTE_W'({h, 4'b0000}) + BYTE_W'(16);
  endfunction

  // region table
  logic [ADDR_W-1:0] regBase  [NUM_REG];
  logic [4:0]        regLog2  [NUM_REG];
  logic [CNT_W-1:0]  regCount [NUM_REG];
  logic [IDX_W-1:0]  regLink  [NUM_REG];

  // per-queue state
  logic [IDX_W-1:0]  qHead  [NUM_QUEUES];
  logic [IDX_W-1:0]  qTail  [NUM_QUEUES];
  logic [CNT_W-1:0]  qCount [NUM_QUEUES];
  logic [BYTE_W-1:0] qBytes [NUM_QUEUES];
  logic [7:0]        qThr   [NUM_QUEUES];

  // latched requests
  logic [QIDX_W-1:0] pQ, oQ;
  logic              pQok, oQok;
  logic [ADDR_W-1:0] pPtr;

  logic              lookHit;
  logic [IDX_W-1:0]  lookIdx;
  logic [REG_W-1:0]  lookReg;
  logic [ADDR_W-1:0] revAddr;
  logic              pushGood;

  logic              linkWe, infoWe;
  logic [IDX_W-1:0]  linkAddr, infoAddr, linkRd;
  logic [REG_W+3:0]  infoRd;

  qmRegionMap #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .NUM_DESC(NUM_DESC)) u_map (
    .regBase(regBase), .regLog2(regLog2), .regCount(regCount), .regLink(regLink),
    .lookAddr({pPtr[ADDR_W-1:4], 4'b0000}),
    .lookHit(lookHit), .lookIdx(lookIdx), .lookReg(lookReg),
    .revReg(infoRd[REG_W+3:4]), .revIdx(qHead[oQ]), .revAddr(revAddr)
  );

  assign pushGood = pQok && lookHit;

  always_comb begin
    linkWe   = stb.doPush && pushGood && (qCount[pQ] != '0);
    infoWe   = stb.doPush && pushGood;
    linkAddr = stb.doPush ? qTail[pQ] : qHead[oQ];
    infoAddr = stb.doPush ? lookIdx : qHead[oQ];
  end

  qmLinkRam #(.DEPTH(NUM_DESC), .WIDTH(IDX_W)) u_link (
    .clk(clk), .we(linkWe), .addr(linkAddr), .wdata(lookIdx), .rdata(linkRd)
  );

  qmLinkRam #(.DEPTH(NUM_DESC), .WIDTH(REG_W + 4)) u_info (
    .clk(clk), .we(infoWe), .addr(infoAddr), .wdata({lookReg, pPtr[3:0]}),
    .rdata(infoRd)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REG; r++) begin
        regBase[r]  <= '0;
        regLog2[r]  <= 5'd4;
        regCount[r] <= '0;
        regLink[r]  <= '0;
      end
    end else if (cfgWr) begin
      regBase[cfgSel]  <= cfgBase;
      regLog2[cfgSel]  <= cfgLog2;
      regCount[cfgSel] <= cfgCount;
      regLink[cfgSel]  <= cfgLink;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pQ <= '0; oQ <= '0; pQok <= 1'b0; oQok <= 1'b0; pPtr <= '0;
    end else begin
      if (stb.latchPush) begin
        pQ   <= relQ(pushQueue);
        pQok <= inWin(pushQueue);
        pPtr <= pushPtr;
      end
      if (stb.latchPop) begin
        oQ   <= relQ(popQueue);
        oQok <= inWin(popQueue);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        qHead[q]  <= '0;
        qTail[q]  <= '0;
        qCount[q] <= '0;
        qBytes[q] <= '0;
        qThr[q]   <= '0;
      end
      popData <= '0;
      popDone <= 1'b0;
      pushErr <= 1'b0;
    end else begin
      popDone <= stb.popFin;
      pushErr <= stb.doPush && !pushGood;
      if (thrWr && inWin(thrQueue)) qThr[relQ(thrQueue)] <= thrData;
      if (stb.doPush && pushGood) begin
        if (qCount[pQ] == '0) qHead[pQ] <= lookIdx;
        qTail[pQ]  <= lookIdx;
        qCount[pQ] <= qCount[pQ] + 1'b1;
        qBytes[pQ] <= qBytes[pQ] + hintBytes(pPtr[3:0]);
      end
      if (stb.popFin) begin
        if (oQok && (qCount[oQ] != '0)) begin
          popData    <= {revAddr[ADDR_W-1:4], infoRd[3:0]};
          qHead[oQ]  <= linkRd;
          qCount[oQ] <= qCount[oQ] - 1'b1;
          qBytes[oQ] <= qBytes[oQ] - hintBytes(infoRd[3:0]);
        end else begin
          popData <= '0;
        end
      end
    end
  end

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_flag
    assign thrFlag[q] = qThr[q][7] ? (int'(qCount[q]) >= int'(qThr[q][6:0]))
                                   : (int'(qCount[q]) <  int'(qThr[q][6:0]));
  end

  assign statCount = inWin(statQueue) ? qCount[relQ(statQueue)] : '0;
  assign statBytes = inWin(statQueue) ? qBytes[relQ(statQueue)] : '0;
endmodule

// File: rtl/qmQueueMgr.sv
module qmQueueMgr
  import qmPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int QNUM_W     = 8,
  parameter int NUM_QUEUES = 8,
  parameter int QUEUE_BASE = 16,
  parameter int NUM_DESC   = 64,
  parameter int NUM_REG    = 2,
  localparam int IDX_W  = $clog2(NUM_DESC),
  localparam int CNT_W  = $clog2(NUM_DESC + 1),
  localparam int BYTE_W = CNT_W + 8,
  localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pushValid,
  input  logic [QNUM_W-1:0]     pushQueue,
  input  logic [ADDR_W-1:0]     pushPtr,
  input  logic                  popValid,
  input  logic [QNUM_W-1:0]     popQueue,
  input  logic                  cfgWr,
  input  logic [REG_W-1:0]      cfgSel,
  input  logic [ADDR_W-1:0]     cfgBase,
  input  logic [4:0]            cfgLog2,
  input  logic [CNT_W-1:0]      cfgCount,
  input  logic [IDX_W-1:0]      cfgLink,
  input  logic                  thrWr,
  input  logic [QNUM_W-1:0]     thrQueue,
  input  logic [7:0]            thrData,
  input  logic [QNUM_W-1:0]     statQueue,
  output logic [CNT_W-1:0]      statCount,
  output logic [BYTE_W-1:0]     statBytes,
  output logic [NUM_QUEUES-1:0] thrFlag,
  output logic                  busy,
  output logic [ADDR_W-1:0]     popData,
  output logic                  popDone,
  output logic                  pushErr
);
  qmStrobe_t stb;

  qmCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popValid(popValid),
    .stb(stb), .busy(busy)
  );

  qmDatapath #(
    .ADDR_W(ADDR_W), .QNUM_W(QNUM_W), .NUM_QUEUES(NUM_QUEUES),
    .QUEUE_BASE(QUEUE_BASE), .NUM_DESC(NUM_DESC), .NUM_REG(NUM_REG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .pushQueue(pushQueue), .pushPtr(pushPtr), .popQueue(popQueue),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgBase(cfgBase), .cfgLog2(cfgLog2),
    .cfgCount(cfgCount), .cfgLink(cfgLink),
    .thrWr(thrWr), .thrQueue(thrQueue), .thrData(thrData),
    .statQueue(statQueue), .statCount(statCount), .statBytes(statBytes),
    .thrFlag(thrFlag), .popData(popData), .popDone(popDone), .pushErr(pushErr)
  );
endmodule

// File: rtl/qmQueueMgrChk.sv
module qmQueueMgrChk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic popDone,
  input logic pushErr
);
  AST_POP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    popDone |-> ($past(busy, 1) && $past(busy, 2))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    popDone |=> !popDone); // R9

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pushErr |=> !pushErr); // R4

  AST_ERR_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pushErr |-> $past(busy)); // R9

  AST_ERR_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(pushErr && popDone)); // R8
endmodule

bind qmQueueMgr qmQueueMgrChk i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .popDone(popDone), .pushErr(pushErr)
);

// File: tb/test_qmQueueMgr.sv
module test_qmQueueMgr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 1'b0, popValid = 1'b0, cfgWr = 1'b0, thrWr = 1'b0;
  logic [7:0]  pushQueue = '0, popQueue = '0, thrQueue = '0, statQueue = '0;
  logic [31:0] pushPtr = '0, cfgBase = '0;
  logic        cfgSel = 1'b0;
  logic [4:0]  cfgLog2 = 5'd4;
  logic [6:0]  cfgCount = '0;
  logic [5:0]  cfgLink = '0;
  logic [7:0]  thrData = '0;
  logic [6:0]  statCount;
  logic [14:0] statBytes;
  logic [7:0]  thrFlag;
  logic        busy, popDone, pushErr;
  logic [31:0] popData;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] model [8][$];
  int          mBytes [8];
  logic [31:0] sb [$];

  always #10 clk = ~clk;

  qmQueueMgr i_qmQueueMgr (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushQueue(pushQueue),
    .pushPtr(pushPtr), .popValid(popValid), .popQueue(popQueue),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgBase(cfgBase), .cfgLog2(cfgLog2),
    .cfgCount(cfgCount), .cfgLink(cfgLink), .thrWr(thrWr), .thrQueue(thrQueue),
    .thrData(thrData), .statQueue(statQueue), .statCount(statCount),
    .statBytes(statBytes), .thrFlag(thrFlag), .busy(busy), .popData(popData),
    .popDone(popDone), .pushErr(pushErr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && popDone) begin
      if (sb.size() == 0) chk("R2 unexpected popDone", 32'd1, 32'd0);
      else chk("R2/R5 popData", popData, sb.pop_front());
    end
  end

  task automatic setRegion(bit sel, logic [31:0] base, logic [4:0] lg,
                           logic [6:0] cnt, logic [5:0] lnk);
    @(negedge clk);
    cfgWr = 1; cfgSel = sel; cfgBase = base; cfgLog2 = lg; cfgCount = cnt; cfgLink = lnk;
    @(negedge clk);
    cfgWr = 0;
  endtask

  task automatic setThr(logic [7:0] q, logic [7:0] d);
    @(negedge clk);
    thrWr = 1; thrQueue = q; thrData = d;
    @(negedge clk);
    thrWr = 0;
  endtask

  task automatic pushOp(logic [7:0] q, logic [31:0] ptr, bit expErr, string tag);
    @(negedge clk);
    pushValid = 1; pushQueue = q; pushPtr = ptr;
    @(negedge clk);
    pushValid = 0;
    chk({tag, " busy during push (R9)"}, 32'(busy), 32'd1);
    @(negedge clk);
    chk({tag, " pushErr"}, 32'(pushErr), 32'(expErr));
    if (!expErr) begin
      model[q-16].push_back(ptr);
      mBytes[q-16] += (int'(ptr[3:0]) + 1) * 16;
    end
  endtask

  task automatic expectPop(logic [7:0] q);
    if (q >= 16 && q < 24 && model[q-16].size() > 0) begin
      logic [31:0] v;
      v = model[q-16].pop_front();
      mBytes[q-16] -= (int'(v[3:0]) + 1) * 16;
      sb.push_back(v);
    end else sb.push_back(32'd0);
  endtask

  task automatic popOp(logic [7:0] q);
    @(negedge clk);
    popValid = 1; popQueue = q;
    expectPop(q);
    @(negedge clk);
    popValid = 0;
    chk("R9 busy pop cycle1", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R9 busy pop cycle2", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R9 popDone after pop", 32'(popDone), 32'd1);
    chk("R9 busy low after pop", 32'(busy), 32'd0);
  endtask

  task automatic checkStat(logic [7:0] q, string tag);
    int c, b;
    c = (q >= 16 && q < 24) ? model[q-16].size() : 0;
    b = (q >= 16 && q < 24) ? mBytes[q-16] : 0;
    @(negedge clk);
    statQueue = q;
    #1;
    chk({tag, " count"}, 32'(statCount), 32'(c));
    chk({tag, " bytes"}, 32'(statBytes), 32'(b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) mBytes[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 popDone", 32'(popDone), 0);
    chk("R1 pushErr", 32'(pushErr), 0);
    chk("R1 thrFlag", 32'(thrFlag), 0);
    checkStat(8'd16, "R1 q16");
    rstN = 1;

    setRegion(1'b0, 32'h0000_1000, 5'd6, 7'd16, 6'd0);
    setRegion(1'b1, 32'h0002_0000, 5'd7, 7'd8, 6'd32);

    // R2 R3 R6 FIFO order across both regions
    pushOp(8'd16, 32'h0000_1043, 0, "R3 region0");
    pushOp(8'd16, 32'h0002_0085, 0, "R3 region1");
    pushOp(8'd16, 32'h0000_100F, 0, "R3 region0 first");
    checkStat(8'd16, "R6 q16 after pushes");

    // R4 rejected pushes
    pushOp(8'd16, 32'h0000_3000, 1, "R4 outside");
    pushOp(8'd16, 32'h0000_1050, 1, "R4 misaligned");
    pushOp(8'd16, 32'h0002_0400, 1, "R4 past region end");
    pushOp(8'd5,  32'h0000_1080, 1, "R4 queue below window");
    pushOp(8'd24, 32'h0000_1080, 1, "R4 queue above window");
    checkStat(8'd16, "R4 q16 unchanged");

    popOp(8'd16); popOp(8'd16);
    checkStat(8'd16, "R6 q16 mid");
    popOp(8'd16);
    checkStat(8'd16, "R6 q16 drained");

    // R5 empty and out of window
    popOp(8'd16);
    popOp(8'd3);
    checkStat(8'd16, "R5 q16 still empty");

    // R2 interleaved queues, last descriptor of region1
    pushOp(8'd17, 32'h0000_1080, 0, "R2 q17 a");
    pushOp(8'd18, 32'h0002_0102, 0, "R2 q18 a");
    pushOp(8'd17, 32'h0000_10C1, 0, "R2 q17 b");
    pushOp(8'd18, 32'h0002_0380, 0, "R3 region1 last slot");
    popOp(8'd18);
    popOp(8'd17);
    checkStat(8'd17, "R6 q17");
    checkStat(8'd18, "R6 q18");
    popOp(8'd18);

    // R7 threshold
    setThr(8'd19, 8'h82);
    setThr(8'd20, 8'h03);
    setThr(8'd99, 8'h81);
    @(negedge clk);
    chk("R7 gte flag at 0", 32'(thrFlag[3]), 0);
    chk("R7 lt flag at 0", 32'(thrFlag[4]), 1);
    pushOp(8'd19, 32'h0000_1140, 0, "R7 q19 a");
    chk("R7 gte flag at 1", 32'(thrFlag[3]), 0);
    pushOp(8'd19, 32'h0000_1180, 0, "R7 q19 b");
    chk("R7 gte flag at 2", 32'(thrFlag[3]), 1);
    pushOp(8'd20, 32'h0000_11C0, 0, "R7 q20 a");
    pushOp(8'd20, 32'h0000_1200, 0, "R7 q20 b");
    pushOp(8'd20, 32'h0000_1240, 0, "R7 q20 c");
    chk("R7 lt flag at 3", 32'(thrFlag[4]), 0);

    // R8 simultaneous push and pop on empty queue
    @(negedge clk);
    pushValid = 1; pushQueue = 8'd21; pushPtr = 32'h0000_1100;
    popValid = 1; popQueue = 8'd21;
    model[5].push_back(32'h0000_1100);
    mBytes[5] += 16;
    expectPop(8'd21);
    @(negedge clk);
    pushValid = 0; popValid = 0;
    repeat (3) @(negedge clk);
    chk("R8 popDone after push+pop", 32'(popDone), 1);
    checkStat(8'd21, "R8 q21 empty");

    // R9 push while busy is dropped
    pushOp(8'd22, 32'h0000_1280, 0, "R9 q22 seed");
    @(negedge clk);
    popValid = 1; popQueue = 8'd17;
    expectPop(8'd17);
    @(negedge clk);
    popValid = 0;
    pushValid = 1; pushQueue = 8'd22; pushPtr = 32'h0000_12C0;
    @(negedge clk);
    pushValid = 0;
    @(negedge clk);
    checkStat(8'd22, "R9 push while busy dropped");
    checkStat(8'd17, "R9 q17 after pop");

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 32'(sb.size()), 0);
    summary();
  end
endmodule